// File: doc/BRIEF.md
# Pseudo-Random Noise Tone Channel

This block is the noise voice of a sound generator. A down-counting timer runs on every clock. When it reaches zero it reloads from a fixed, non-linear 16-entry period table, and it advances a 15-bit linear feedback shift register by one step. The register's low bit gates the voice, so the output is a pseudo-random on/off pattern. A mode bit picks the feedback tap. The long-sequence tap gives a hiss, and the short-sequence tap gives a buzzy, metallic tone.

The 4-bit output sample is the envelope volume supplied from outside. It is forced to zero whenever the shift register's low bit is set or the length counter has run out. The length counter is loaded from a 32-entry table through a register write. It counts down on an external half-frame strobe unless it is halted. Clearing the channel enable empties it at once. Software reaches the voice through a small write port with a 2-bit register select.

Top module: `noise_voice`

## Requirements
- R1: While reset is held, and on the first cycle after it, `sample` is 0. Reset puts the shift register at 1, the timer at 0, the length counter at 0, and clears halt, mode and period index.
- R2: A write with `wr_sel`=1 stores the period index from `wr_data[3:0]`. Each clock, a timer at 0 reloads with the table period and a nonzero timer decrements by one. The table by index 0..15 is 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068, so the shift register steps once every period+1 clocks.
- R3: On each timer expiry the shift register moves one place right and the feedback bit enters bit 14. In long mode (`wr_data[7]`=0 at the `wr_sel`=1 write) the feedback is bit0 XOR bit1.
- R4: In short mode (`wr_data[7]`=1 at the `wr_sel`=1 write) the feedback is bit0 XOR bit6.
- R5: `sample` equals `env_vol` when shift register bit 0 is 0 and the length counter is nonzero; otherwise it is 0.
- R6: While `chan_en` is low the length counter becomes 0 on the next clock. A length write made while disabled has no effect.
- R7: A write with `wr_sel`=2 while `chan_en` is high loads the length counter from a 32-entry table indexed by `wr_data[7:3]`. Index 1 gives 254, any other odd index k gives k-1, and even indices 0,2,..,30 give 10,20,40,80,160,60,14,26,12,24,48,96,192,72,16,32.
- R8: A `half_frame` pulse decrements a nonzero length counter unless the halt flag is set. The halt flag is `wr_data[0]` of a `wr_sel`=0 write. A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timer counts once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 mode/period, 2 length, 3 none |
| wr_data | input | 8 | Write data |
| chan_en | input | 1 | Channel enable; low empties the length counter |
| half_frame | input | 1 | Length counter clock strobe |
| env_vol | input | 4 | Envelope volume from the envelope generator |
| sample | output | 4 | Gated output sample |

## Verification
The bench targets the longest period, 4068. Testing that index checks the full timer width and the table's last entry; a short timer or a wrong table entry shifts the step cadence and the gating pattern drifts within a few thousand cycles. It switches between long and short feedback mid-run, where a wrong tap makes the bit-0 mute sequence diverge almost at once. It runs the length counter down to zero under strobes, holds it with halt, and drops the enable mid-count. It also writes a length while disabled. A design that reloads while disabled, decrements past zero or ignores halt leaves the voice audible when it should be silent, or silent when it should sound.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int TMR_W  = 12;
  localparam int LFSR_W = 15;
  localparam int LEN_W  = 8;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_MODEPER = 2'd1,
    SEL_LEN     = 2'd2,
    SEL_NONE    = 2'd3
  } wsel_e;

  function automatic logic [TMR_W-1:0] period_of(input logic [3:0] idx);
    logic [TMR_W-1:0] p;
    case (idx)
      4'd0:  p = 12'd4;
      4'd1:  p = 12'd8;
      4'd2:  p = 12'd16;
      4'd3:  p = 12'd32;
      4'd4:  p = 12'd64;
      4'd5:  p = 12'd96;
      4'd6:  p = 12'd128;
      4'd7:  p = 12'd160;
      4'd8:  p = 12'd202;
      4'd9:  p = 12'd254;
      4'd10: p = 12'd380;
      4'd11: p = 12'd508;
      4'd12: p = 12'd762;
      4'd13: p = 12'd1016;
      4'd14: p = 12'd2034;
      default: p = 12'd4068;
    endcase
    return p;
  endfunction

  function automatic logic [LEN_W-1:0] length_of(input logic [4:0] idx);
    logic [LEN_W-1:0] l;
    if (idx[0]) begin
      l = (idx == 5'd1) ? 8'd254 : {3'd0, idx} - 8'd1;
    end else begin
      case (idx[4:1])
        4'd0:  l = 8'd10;
        4'd1:  l = 8'd20;
        4'd2:  l = 8'd40;
        4'd3:  l = 8'd80;
        4'd4:  l = 8'd160;
        4'd5:  l = 8'd60;
        4'd6:  l = 8'd14;
        4'd7:  l = 8'd26;
        4'd8:  l = 8'd12;
        4'd9:  l = 8'd24;
        4'd10: l = 8'd48;
        4'd11: l = 8'd96;
        4'd12: l = 8'd192;
        4'd13: l = 8'd72;
        4'd14: l = 8'd16;
        default: l = 8'd32;
      endcase
    end
    return l;
  endfunction

  function automatic logic feedback_of(input logic [LFSR_W-1:0] s,
                                       input logic short_mode);
    return s[0] ^ (short_mode ? s[6] : s[1]);
  endfunction
endpackage

// File: rtl/noise_timer.sv
module noise_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] reload_val,
  output logic         expire,
  output logic [W-1:0] count
);
  assign expire = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (expire) count <= reload_val;
    else             count <= count - 1'b1;
  end
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         short_mode,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = noise_pkg::feedback_of(state, short_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= W'(1);
    else if (step) state <= {fb, state[W-1:1]};
  end
endmodule

// File: rtl/noise_length.sv
module noise_length #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         halt,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         empty
);
  assign empty = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (!enable)                count <= '0;
    else if (load)                   count <= load_val;
    else if (dec && !halt && !empty) count <= count - 1'b1;
  end
endmodule

// File: rtl/noise_voice.sv
module noise_voice
  import noise_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       chan_en,
  input  logic       half_frame,
  input  logic [3:0] env_vol,
  output logic [3:0] sample
);
  logic              halt_q, short_q;
  logic [3:0]        per_idx_q;
  logic              tmr_expire, len_empty, len_load;
  logic [TMR_W-1:0]  tmr_count;
  logic [LFSR_W-1:0] lfsr_state;
  logic [LEN_W-1:0]  len_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q    <= 1'b0;
      short_q   <= 1'b0;
      per_idx_q <= '0;
    end else if (wr_en) begin
      case (wsel_e'(wr_sel))
        SEL_CTRL:    halt_q <= wr_data[0];
        SEL_MODEPER: begin
          short_q   <= wr_data[7];
          per_idx_q <= wr_data[3:0];
        end
        default: ;
      endcase
    end
  end

  assign len_load = wr_en && (wsel_e'(wr_sel) == SEL_LEN);

  noise_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload_val(period_of(per_idx_q)),
    .expire(tmr_expire), .count(tmr_count)
  );

  noise_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(tmr_expire), .short_mode(short_q),
    .state(lfsr_state)
  );

  noise_length #(.W(LEN_W)) u_length (
    .clk(clk), .rst_n(rst_n), .enable(chan_en), .load(len_load),
    .load_val(length_of(wr_data[7:3])), .halt(halt_q), .dec(half_frame),
    .count(len_count), .empty(len_empty)
  );

  assign sample = (lfsr_state[0] || len_empty) ? 4'd0 : env_vol;
endmodule

// File: rtl/noise_voice_chk.sv
module noise_voice_chk
  import noise_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              half_frame,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              halt,
  input logic              tick,
  input logic [TMR_W-1:0]  timer,
  input logic [3:0]        per_idx,
  input logic [LFSR_W-1:0] lfsr,
  input logic [LEN_W-1:0]  len_cnt,
  input logic [3:0]        sample
);
  AST_RESET_SILENT: assert property (@(posedge clk) !rst_n |-> sample == 4'd0); // R1
  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> timer == period_of($past(per_idx))); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lfsr)); // R3
  AST_SHIFT_RIGHT:  assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> lfsr[LFSR_W-2:0] == $past(lfsr[LFSR_W-1:1])); // R3
  AST_LFSR_LIVE:    assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R4
  AST_MUTE_EMPTY:   assert property (@(posedge clk) disable iff (!rst_n)
    len_cnt == '0 |-> sample == 4'd0); // R5
  AST_DISABLE_CLR:  assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> len_cnt == '0); // R6
  AST_LEN_DEC:      assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && half_frame && !halt && len_cnt != '0 && !(wr_en && wr_sel == 2'd2))
    |=> len_cnt == $past(len_cnt) - 1'b1); // R8
  AST_LEN_HALT:     assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && halt && !(wr_en && wr_sel == 2'd2)) |=> $stable(len_cnt)); // R8
endmodule

bind noise_voice noise_voice_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .half_frame(half_frame),
  .wr_en(wr_en), .wr_sel(wr_sel), .halt(halt_q), .tick(tmr_expire),
  .timer(tmr_count), .per_idx(per_idx_q), .lfsr(lfsr_state),
  .len_cnt(len_count), .sample(sample)
);

// File: tb/test_noise_voice.sv
`timescale 1ns/1ps
module test_noise_voice;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       chan_en = 1'b0;
  logic       half_frame = 1'b0;
  logic [3:0] env_vol = 4'd0;
  logic [3:0] sample;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  noise_voice i_noise_voice (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .chan_en(chan_en), .half_frame(half_frame), .env_vol(env_vol), .sample(sample)
  );

  int per_tab [16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};
  int len_tab [32] = '{10, 254, 20, 2, 40, 4, 80, 6, 160, 8, 60, 10, 14, 12, 26, 14,
                       12, 16, 24, 18, 48, 20, 96, 22, 192, 24, 72, 26, 16, 28, 32, 30};

  // reference state
  int m_tmr = 0, m_sr = 1, m_len = 0, m_idx = 0;
  bit m_short = 0, m_halt = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: sample=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver-side model: pushes the expected sample for every clock
  always @(posedge clk) begin
    if (rst_n) begin
      int tap;
      if (m_tmr == 0) begin
        tap = m_short ? 6 : 1;
        m_sr = (m_sr >> 1) | ((((m_sr >> tap) ^ m_sr) & 1) << 14);
        m_tmr = per_tab[m_idx];
      end else m_tmr = m_tmr - 1;
      if (!chan_en) m_len = 0;
      else if (wr_en && wr_sel == 2'd2) m_len = len_tab[wr_data[7:3]];
      else if (half_frame && !m_halt && m_len > 0) m_len = m_len - 1;
      if (wr_en && wr_sel == 2'd0) m_halt = wr_data[0];
      if (wr_en && wr_sel == 2'd1) begin m_short = wr_data[7]; m_idx = wr_data[3:0]; end
      exp_q.push_back(((m_sr % 2) == 1 || m_len == 0) ? 4'd0 : env_vol);
      tag_q.push_back(phase);
    end
  end

  // monitor
  always @(posedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, sample, e);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'hA5;
  endtask

  task automatic run(input int cycles, input int strobe_every);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      env_vol = 4'((i * 7 + 3) % 16);
      half_frame = (strobe_every > 0) && (i % strobe_every == 0);
    end
    @(negedge clk);
    half_frame = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not end expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    env_vol = 4'd15;
    repeat (3) @(negedge clk);
    check("R1 reset", sample, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", sample, 0);

    phase = "R3 long mode, R7 load, R5 gating";
    chan_en = 1'b1;
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd1 << 3);
    run(400, 0);

    phase = "R4 short mode";
    wr(2'd1, 8'h80);
    run(300, 0);

    phase = "R2 period idx 3";
    wr(2'd1, 8'h03);
    run(600, 0);
    phase = "R2 period idx 9 short";
    wr(2'd1, 8'h89);
    run(1500, 0);
    phase = "R2 period idx 15";
    wr(2'd1, 8'h0F);
    run(12500, 0);
    phase = "R2 period idx 0";
    wr(2'd1, 8'h00);
    run(200, 0);

    phase = "R8 halt holds length";
    wr(2'd2, 8'd3 << 3);
    run(200, 3);
    phase = "R8 decrement to zero";
    wr(2'd0, 8'h00);
    wr(2'd2, 8'd3 << 3);
    run(100, 4);
    phase = "R7 even index load, R8 countdown";
    wr(2'd2, 8'd0 << 3);
    run(300, 5);
    phase = "R8 sel 3 ignored";
    wr(2'd2, 8'd30 << 3);
    wr(2'd3, 8'hFF);
    run(200, 0);

    phase = "R6 disable clears";
    @(negedge clk); chan_en = 1'b0;
    run(50, 0);
    phase = "R6 load while disabled ignored";
    wr(2'd2, 8'd1 << 3);
    run(50, 0);
    phase = "R7 reenable and load";
    chan_en = 1'b1;
    wr(2'd2, 8'd9 << 3);
    run(200, 0);

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule